// File: doc/BRIEF.md
# Two's Complement Adder-Subtractor with Triple Overflow Judgement

This block adds or subtracts two W-bit two's complement operands. One control input selects the operation. When it is high, the second operand goes through a bank of per-bit inverters and a 2:1 selector, and the same control is fed into the ripple adder as the carry-in. So subtraction is done as the first operand plus the bitwise inverse of the second operand plus one.

Signed overflow is worked out in three independent ways:
- a comparison of the sign of the two effective addends with the sign of the sum;
- a comparison of the carry entering the top bit with the carry leaving it;
- a separate W+1-bit sum over operands extended to two sign bits.

The overflow output is the two-of-three vote of these methods. The upper bit of the double-sign sum is also output as the true sign of the exact result. If the three methods ever disagree, an internal error flag is raised. All results are registered one cycle after an accepted input.

Top module: `twos_addsub`

## Requirements
- R1: While `rst` is high at a clock edge, on the next cycle `out_valid`, `result`, `carry_out`, `overflow`, `true_sign` and `ovf_mismatch` are all 0.
- R2: `out_valid` is high in the cycle after a clock edge where `in_valid` was high. It is low in the cycle after an edge where `in_valid` was low.
- R3: With `sub`=0, `result` is (`a`+`b`) mod 2^W and `carry_out` is bit W of the unsigned sum.
- R4: With `sub`=1, `result` is (`a`-`b`) mod 2^W and `carry_out` is 1 exactly when `a` >= `b` taken as unsigned numbers (no borrow).
- R5: `overflow` is 1 exactly when the signed result of the selected operation lies outside the range from -2^(W-1) to 2^(W-1)-1.
- R6: `overflow` is 0 whenever the effective addends differ in sign. For addition this means the signs of `a` and `b` differ; for subtraction it means they match.
- R7: `true_sign` is 1 exactly when the exact, unwrapped signed result is negative. This holds also on overflow.
- R8: `ovf_mismatch` is never 1, because the three overflow methods always agree.
- R9: An edge with `in_valid` low leaves `result`, `carry_out`, `overflow` and `true_sign` unchanged, whatever the values on `a`, `b` and `sub`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and control are valid this cycle |
| a | input | W | First operand, two's complement |
| b | input | W | Second operand, two's complement |
| sub | input | 1 | 1 = subtract `b` from `a`, 0 = add |
| out_valid | output | 1 | Registered result is fresh |
| result | output | W | Registered sum or difference |
| carry_out | output | 1 | Carry leaving the top adder bit |
| overflow | output | 1 | Signed overflow (vote of three methods) |
| true_sign | output | 1 | Sign of the exact result, from the double sign bit |
| ovf_mismatch | output | 1 | Overflow methods disagreed |

## Verification
The bench builds the block with W=8 instead of the default 16. With that width, every value of `a` can be paired with a spread of `b` values in both operations within a short run. The extreme values -128 and 127 and the wrap across zero are hit directly, so every overflow direction, with and without borrow, is reached many times. The smaller width also lets the reference model use plain integer arithmetic with no risk of wrapping itself.

// File: rtl/twos_addsub_pkg.sv
package twos_addsub_pkg;

    // One flag per overflow method
    typedef struct packed {
        logic by_sign;   // addend signs versus sum sign
        logic by_carry;  // carry into top bit versus carry out of it
        logic by_dbl;    // double sign bit disagreement
    } ovf_votes_t;

    // Registered flag bundle
    typedef struct packed {
        logic valid;
        logic carry;
        logic ovf;
        logic sign;
        logic err;
    } flag_reg_t;

    localparam flag_reg_t FLAGS_CLEAR = '{valid: 1'b0, carry: 1'b0, ovf: 1'b0,
                                          sign: 1'b0, err: 1'b0};

    function automatic logic votes_agree(input ovf_votes_t v);
        return (v.by_sign == v.by_carry) && (v.by_carry == v.by_dbl);
    endfunction

    function automatic logic votes_major(input ovf_votes_t v);
        return (v.by_sign & v.by_carry) | (v.by_sign & v.by_dbl) |
               (v.by_carry & v.by_dbl);
    endfunction

endpackage

// File: rtl/as_operand_sel.sv
module as_operand_sel #(
    parameter int W = 16
) (
    input  logic [W-1:0] y_in,
    input  logic         invert,
    output logic [W-1:0] y_eff
);
    logic [W-1:0] y_not;

    // One inverter and one 2:1 selector per bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y_not[i] = ~y_in[i];
        assign y_eff[i] = invert ? y_not[i] : y_in[i];
    end
endmodule

// File: rtl/as_ripple_core.sv
module as_ripple_core #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_top_in,
    output logic         c_top_out
);
    logic [W:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]  = x[i] ^ y[i] ^ c[i];
        assign c[i+1]  = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
    end

    assign c_top_in  = c[W-1];
    assign c_top_out = c[W];
endmodule

// File: rtl/as_ovf_judge.sv
module as_ovf_judge
    import twos_addsub_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic [W-1:0] sum,
    input  logic         c_top_in,
    input  logic         c_top_out,
    output ovf_votes_t   votes,
    output logic         exact_neg
);
    localparam int XW = W + 1;

    logic [XW-1:0] x_dbl, y_dbl, s_dbl;

    // Method: like-signed addends producing an opposite-signed sum
    assign votes.by_sign  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

    // Method: top two carries differ
    assign votes.by_carry = c_top_in ^ c_top_out;

    // Method: two sign bits, independent adder
    assign x_dbl = {x[W-1], x};
    assign y_dbl = {y[W-1], y};
    assign s_dbl = x_dbl + y_dbl + XW'(cin);
    assign votes.by_dbl   = s_dbl[XW-1] ^ s_dbl[XW-2];
    assign exact_neg      = s_dbl[XW-1];
endmodule

// File: rtl/twos_addsub.sv
module twos_addsub
    import twos_addsub_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         overflow,
    output logic         true_sign,
    output logic         ovf_mismatch
);
    logic [W-1:0] y_eff, sum_c;
    logic         c_in_top, c_out_top, neg_c;
    ovf_votes_t   votes_c;
    flag_reg_t    flags_q;
    logic [W-1:0] result_q;

    as_operand_sel #(.W(W)) u_sel (
        .y_in   (b),
        .invert (sub),
        .y_eff  (y_eff)
    );

    as_ripple_core #(.W(W)) u_core (
        .x         (a),
        .y         (y_eff),
        .cin       (sub),
        .sum       (sum_c),
        .c_top_in  (c_in_top),
        .c_top_out (c_out_top)
    );

    as_ovf_judge #(.W(W)) u_judge (
        .x         (a),
        .y         (y_eff),
        .cin       (sub),
        .sum       (sum_c),
        .c_top_in  (c_in_top),
        .c_top_out (c_out_top),
        .votes     (votes_c),
        .exact_neg (neg_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= FLAGS_CLEAR;
            result_q <= '0;
        end else begin
            flags_q.valid <= in_valid;
            if (in_valid) begin
                result_q      <= sum_c;
                flags_q.carry <= c_out_top;
                flags_q.ovf   <= votes_major(votes_c);
                flags_q.sign  <= neg_c;
                flags_q.err   <= ~votes_agree(votes_c);
            end
        end
    end

    assign out_valid    = flags_q.valid;
    assign result       = result_q;
    assign carry_out    = flags_q.carry;
    assign overflow     = flags_q.ovf;
    assign true_sign    = flags_q.sign;
    assign ovf_mismatch = flags_q.err;

    // R2: valid follows the accepted input by one cycle
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6: addends of opposite effective sign never overflow
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (a[W-1] != (b[W-1] ^ sub))) |=> !overflow);

    // R7: without overflow the true sign is the result's top bit
    a_r7_sign_match: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !overflow) |-> (true_sign == result[W-1]));

    // R8: the three methods never disagree
    a_r8_no_mismatch: assert property (@(posedge clk) disable iff (rst)
        !ovf_mismatch);

    // R9: idle cycles keep the registered result
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(overflow) && $stable(carry_out)));
endmodule

// File: tb/twos_addsub_tb_top.sv
module twos_addsub_tb_top;
    localparam int  W       = 8;
    localparam time CLK_PER = 10ns;
    localparam longint MAXP = (64'sd1 <<< (W-1)) - 1;
    localparam longint MINN = -(64'sd1 <<< (W-1));

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [W-1:0] a, b;
    logic         sub;
    logic         out_valid, carry_out, overflow, true_sign, ovf_mismatch;
    logic [W-1:0] result;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    twos_addsub #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .sub(sub),
        .out_valid(out_valid), .result(result), .carry_out(carry_out),
        .overflow(overflow), .true_sign(true_sign), .ovf_mismatch(ovf_mismatch)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one operation and compare against an integer model
    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic op);
        longint sa, sb, ex, ua, ub, usum;
        sa = longint'($signed(av));
        sb = longint'($signed(bv));
        ex = op ? sa - sb : sa + sb;
        ua = longint'(av);
        ub = longint'(bv);
        usum = op ? ua + ((~ub) & ((64'd1 << W) - 1)) + 1 : ua + ub;
        @(negedge clk);
        a = av; b = bv; sub = op; in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check("R2", out_valid, 1);
        if (op) begin
            check("R4", result, ex & ((64'd1 << W) - 1));
            check("R4", carry_out, (ua >= ub) ? 1 : 0);
        end else begin
            check("R3", result, ex & ((64'd1 << W) - 1));
            check("R3", carry_out, (usum >> W) & 1);
        end
        check("R5", overflow, (ex > MAXP || ex < MINN) ? 1 : 0);
        if ((sa < 0) != (op ? (sb >= 0) : (sb < 0)))
            check("R6", overflow, 0);
        check("R7", true_sign, (ex < 0) ? 1 : 0);
        check("R8", ovf_mismatch, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; a = '0; b = '0; sub = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", out_valid, 0);
        check("R1", result, 0);
        check("R1", {carry_out, overflow, true_sign, ovf_mismatch}, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_basic();
        apply(8'd3, 8'd4, 1'b0);
        apply(8'd10, 8'd3, 1'b1);
        apply(8'd3, 8'd10, 1'b1);
        apply(8'hFF, 8'h01, 1'b0);
        apply(8'd0, 8'd0, 1'b1);
    endtask

    task automatic t_overflow_edges();
        apply(8'h7F, 8'h01, 1'b0);   // positive overflow
        apply(8'h80, 8'hFF, 1'b0);   // negative overflow
        apply(8'h80, 8'h80, 1'b0);
        apply(8'h80, 8'h01, 1'b1);   // min minus one
        apply(8'h00, 8'h80, 1'b1);   // zero minus min
        apply(8'h7F, 8'h80, 1'b1);
        apply(8'hFF, 8'h80, 1'b1);   // -1 - min, fits
        apply(8'h7F, 8'h80, 1'b0);   // opposite signs, no overflow
    endtask

    task automatic t_hold();
        logic [W-1:0] r0;
        logic [3:0]   f0;
        apply(8'h40, 8'h40, 1'b0);
        r0 = result;
        f0 = {carry_out, overflow, true_sign, ovf_mismatch};
        @(negedge clk);
        a = 8'h12; b = 8'hF0; sub = 1'b1; in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R2", out_valid, 0);
        check("R9", result, r0);
        check("R9", {carry_out, overflow, true_sign, ovf_mismatch}, f0);
    endtask

    task automatic t_sweep();
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 256; bi += 37) begin
                apply(ai[W-1:0], bi[W-1:0], 1'b0);
                apply(ai[W-1:0], bi[W-1:0], 1'b1);
            end
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_overflow_edges();
        t_hold();
        t_sweep();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule